// File: doc/BRIEF.md
# Scalar Floating-Point Compare to Status Flags

This unit compares two scalar floating-point operands, either single or double precision, and reports the result as six condition flags instead of a bit mask. Three flags carry the relation: zero, parity and carry. The other three (overflow, sign and auxiliary carry) are always written as zero. There are two variants. The quiet variant accepts quiet NaNs without complaint and reports invalid only for a signaling NaN. The signaling variant reports invalid for any NaN.

A request is a one-cycle pulse on `valid_i`. The flags, a one-cycle flag-write strobe and the sticky invalid status all update on the clock edge that samples the request. When the invalid condition is raised and not masked, the flags are left as they were and no write strobe appears, so that a handler can take over.

Top module: `fp_flag_compare`

## Requirements
- R1: If either operand is a NaN, the result is unordered: zf, pf and cf become 1, and of, sf and af become 0.
- R2: If operand A is greater than operand B, all six flags become 0.
- R3: If A is less than B, only cf becomes 1.
- R4: If the operands are equal, only zf becomes 1. Positive zero and negative zero compare equal.
- R5: Every flag update writes of, sf and af as 0.
- R6: With `signaling_i`=1, any NaN operand, quiet or signaling, raises invalid.
- R7: With `signaling_i`=0, only a signaling NaN raises invalid. A NaN whose top fraction bit is 1 is quiet, and one whose top fraction bit is 0 (with a non-zero fraction) is signaling. A quiet NaN gives the unordered flags and raises no invalid.
- R8: If invalid is raised while `inv_mask_i`=0, the flags keep their previous values and `flag_we_o` stays 0.
- R9: `inv_sticky_o` is set by any raised invalid, masked or not. It is cleared only by reset.
- R10: With `dbl_i`=0, the operands are single precision in bits [31:0] and bits [63:32] are ignored. With `dbl_i`=1, all 64 bits form a double.
- R11: The outputs update one clock edge after `valid_i` is sampled high. With `valid_i` low, `flag_we_o` is 0 and the flags hold.
- R12: After reset, all flags, `flag_we_o` and `inv_sticky_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Compare request |
| signaling_i | input | 1 | 1 = signaling variant, 0 = quiet variant |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision |
| inv_mask_i | input | 1 | 1 = invalid masked |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag |
| af_o | output | 1 | Auxiliary carry flag |
| flag_we_o | output | 1 | Flag write strobe |
| inv_sticky_o | output | 1 | Sticky invalid status |

## Verification
The bench goes after the corner cases that are easy to get wrong. Signed zeros must compare equal; a design that compares raw bit patterns would report less or greater. Negative operands must be ordered by inverted magnitude; getting this wrong flips the less and greater results. The two variants are fed the same quiet NaN, and a design that mixed them up would either fault on a quiet NaN or let one through silently. Single-precision operands are given garbage in their upper half, and a design that forgot to narrow would see a difference there. Finally, an unmasked fault follows a valid result, and a design that overwrote the flags or dropped the sticky bit would show it.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int MAG_W     = DP_EXP_W + DP_FRAC_W;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  typedef struct packed {
    logic             is_nan;
    logic             is_snan;
    logic             is_zero;
    logic             sign;
    logic [MAG_W-1:0] mag;
  } opnd_t;

  // Ordering of two classified operands.
  function automatic rel_e relate(input opnd_t a, input opnd_t b);
    rel_e r;
    if (a.is_nan || b.is_nan)        r = REL_UN;
    else if (a.is_zero && b.is_zero) r = REL_EQ;
    else if (a.sign != b.sign)       r = a.sign ? REL_LT : REL_GT;
    else if (a.mag == b.mag)         r = REL_EQ;
    else if ((a.mag > b.mag) ^ a.sign) r = REL_GT;
    else                             r = REL_LT;
    return r;
  endfunction

  // Relation to {zf, pf, cf}.
  function automatic logic [2:0] zpc_of(input rel_e r);
    logic [2:0] v;
    case (r)
      REL_UN:  v = 3'b111;
      REL_LT:  v = 3'b001;
      REL_EQ:  v = 3'b100;
      default: v = 3'b000;
    endcase
    return v;
  endfunction

  // Invalid decision for the chosen variant.
  function automatic logic invalid_of(input opnd_t a, input opnd_t b, input logic sig_var);
    return sig_var ? (a.is_nan || b.is_nan) : (a.is_snan || b.is_snan);
  endfunction
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] val_i,
  output opnd_t                 info_o
);
  localparam int TOP = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_w;
  logic [FRAC_W-1:0] frac_w;
  logic              exp_ones;
  logic              nan_w;

  assign exp_w    = val_i[TOP-1:FRAC_W];
  assign frac_w   = val_i[FRAC_W-1:0];
  assign exp_ones = &exp_w;
  assign nan_w    = exp_ones && (frac_w != '0);

  always_comb begin
    info_o.is_nan  = nan_w;
    info_o.is_snan = nan_w && !frac_w[FRAC_W-1];
    info_o.is_zero = (val_i[TOP-1:0] == '0);
    info_o.sign    = val_i[TOP];
    info_o.mag     = MAG_W'(val_i[TOP-1:0]);
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
(
  input  opnd_t a_i,
  input  opnd_t b_i,
  input  logic  sig_var_i,
  output rel_e  rel_o,
  output logic  inv_o
);
  assign rel_o = relate(a_i, b_i);
  assign inv_o = invalid_of(a_i, b_i, sig_var_i);
endmodule

// File: rtl/fpcmp_flag_reg.sv
module fpcmp_flag_reg
  import fpcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid_i,
  input  rel_e       rel_i,
  input  logic       inv_i,
  input  logic       inv_mask_i,
  output logic [2:0] zpc_o,
  output logic [2:0] aux_o,
  output logic       we_o,
  output logic       sticky_o
);
  logic fault_w;
  logic commit_w;

  assign fault_w  = inv_i && !inv_mask_i;
  assign commit_w = valid_i && !fault_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zpc_o    <= 3'b000;
      aux_o    <= 3'b000;
      we_o     <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      we_o <= commit_w;
      if (commit_w) begin
        zpc_o <= zpc_of(rel_i);
        aux_o <= 3'b000;
      end
      if (valid_i) sticky_o <= sticky_o | inv_i;
    end
  end
endmodule

// File: rtl/fp_flag_compare.sv
module fp_flag_compare
  import fpcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic        signaling_i,
  input  logic        dbl_i,
  input  logic        inv_mask_i,
  input  logic [63:0] opa_i,
  input  logic [63:0] opb_i,
  output logic        zf_o,
  output logic        pf_o,
  output logic        cf_o,
  output logic        of_o,
  output logic        sf_o,
  output logic        af_o,
  output logic        flag_we_o,
  output logic        inv_sticky_o
);
  localparam int SP_W = SP_EXP_W + SP_FRAC_W + 1;
  localparam int DP_W = DP_EXP_W + DP_FRAC_W + 1;
  localparam int N_OP = 2;

  logic [DP_W-1:0] raw_w [N_OP];
  opnd_t sp_info_w [N_OP];
  opnd_t dp_info_w [N_OP];
  opnd_t sel_info_w [N_OP];

  rel_e       rel_w;
  logic       inv_raise_w;
  logic [2:0] zpc_w;
  logic [2:0] aux_w;

  assign raw_w[0] = opa_i;
  assign raw_w[1] = opb_i;

  for (genvar g = 0; g < N_OP; g++) begin : g_opnd
    fpcmp_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
      .val_i (raw_w[g][SP_W-1:0]),
      .info_o(sp_info_w[g])
    );
    fpcmp_classify #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
      .val_i (raw_w[g]),
      .info_o(dp_info_w[g])
    );
    assign sel_info_w[g] = dbl_i ? dp_info_w[g] : sp_info_w[g];
  end

  fpcmp_order u_order (
    .a_i      (sel_info_w[0]),
    .b_i      (sel_info_w[1]),
    .sig_var_i(signaling_i),
    .rel_o    (rel_w),
    .inv_o    (inv_raise_w)
  );

  fpcmp_flag_reg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .rel_i     (rel_w),
    .inv_i     (inv_raise_w),
    .inv_mask_i(inv_mask_i),
    .zpc_o     (zpc_w),
    .aux_o     (aux_w),
    .we_o      (flag_we_o),
    .sticky_o  (inv_sticky_o)
  );

  assign {zf_o, pf_o, cf_o} = zpc_w;
  assign {of_o, sf_o, af_o} = aux_w;
endmodule

// File: rtl/fpcmp_checker.sv
module fpcmp_checker
  import fpcmp_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic valid_i,
  input logic inv_mask_i,
  input logic zf_o,
  input logic pf_o,
  input logic cf_o,
  input logic of_o,
  input logic sf_o,
  input logic af_o,
  input logic flag_we_o,
  input logic inv_sticky_o,
  input rel_e rel_w,
  input logic inv_raise_w
);
  p_unordered_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && rel_w == REL_UN && !(inv_raise_w && !inv_mask_i) |=> zf_o && pf_o && cf_o);

  p_greater_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && rel_w == REL_GT |=> !zf_o && !pf_o && !cf_o);

  p_aux_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_o |-> !of_o && !sf_o && !af_o);

  p_hold_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && inv_raise_w && !inv_mask_i |=> !flag_we_o && $stable({zf_o, pf_o, cf_o}));

  p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && inv_raise_w |=> inv_sticky_o);

  p_sticky_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_sticky_o |=> inv_sticky_o);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !flag_we_o && $stable({zf_o, pf_o, cf_o, of_o, sf_o, af_o}));
endmodule

bind fp_flag_compare fpcmp_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .valid_i     (valid_i),
  .inv_mask_i  (inv_mask_i),
  .zf_o        (zf_o),
  .pf_o        (pf_o),
  .cf_o        (cf_o),
  .of_o        (of_o),
  .sf_o        (sf_o),
  .af_o        (af_o),
  .flag_we_o   (flag_we_o),
  .inv_sticky_o(inv_sticky_o),
  .rel_w       (rel_w),
  .inv_raise_w (inv_raise_w)
);

// File: tb/fp_flag_compare_tb.sv
module fp_flag_compare_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        signaling_i = 1'b0;
  logic        dbl_i = 1'b0;
  logic        inv_mask_i = 1'b1;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic zf_o, pf_o, cf_o, of_o, sf_o, af_o, flag_we_o, inv_sticky_o;

  int n_run = 0;
  int n_fail = 0;
  logic [2:0] exp_zpc = 3'b000;
  logic       exp_sticky = 1'b0;

  always #2.5 clk = ~clk;

  fp_flag_compare u_dut (.*);

  typedef struct packed {
    logic        sig;
    logic        dbl;
    logic        mask;
    logic [63:0] a;
    logic [63:0] b;
    logic [2:0]  zpc;
    logic        we;
    logic        inv;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 64'h3F800000, 64'h40000000, 3'b001, 1'b1, 1'b0},             // R3
    '{1'b0, 1'b0, 1'b1, 64'h40000000, 64'h3F800000, 3'b000, 1'b1, 1'b0},             // R2
    '{1'b0, 1'b0, 1'b1, 64'h00000000, 64'h80000000, 3'b100, 1'b1, 1'b0},             // R4 signed zero
    '{1'b0, 1'b0, 1'b1, 64'hBF800000, 64'h3F800000, 3'b001, 1'b1, 1'b0},             // R3 sign
    '{1'b0, 1'b0, 1'b1, 64'hBF800000, 64'hC0000000, 3'b000, 1'b1, 1'b0},             // R2 negatives
    '{1'b0, 1'b0, 1'b0, 64'h7FC00000, 64'h3F800000, 3'b111, 1'b1, 1'b0},             // R7 quiet NaN
    '{1'b0, 1'b0, 1'b1, 64'h3F800000, 64'h7F800001, 3'b111, 1'b1, 1'b1},             // R7 signaling NaN
    '{1'b1, 1'b0, 1'b1, 64'h7FC00000, 64'h3F800000, 3'b111, 1'b1, 1'b1},             // R6
    '{1'b0, 1'b1, 1'b1, 64'h3FF0000000000000, 64'h4000000000000000, 3'b001, 1'b1, 1'b0}, // R10
    '{1'b0, 1'b1, 1'b1, 64'h4000000000000000, 64'h3FF0000000000000, 3'b000, 1'b1, 1'b0}, // R10
    '{1'b0, 1'b1, 1'b0, 64'h7FF8000000000000, 64'h3FF0000000000000, 3'b111, 1'b1, 1'b0}, // R1 R7
    '{1'b0, 1'b0, 1'b1, 64'hFFFFFFFF3F800000, 64'h000000003F800000, 3'b100, 1'b1, 1'b0}, // R10 upper ignored
    '{1'b0, 1'b0, 1'b1, 64'h7F800000, 64'h3F800000, 3'b000, 1'b1, 1'b0},             // R2 infinity
    '{1'b0, 1'b1, 1'b1, 64'hC000000000000000, 64'hC000000000000000, 3'b100, 1'b1, 1'b0}  // R4
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_cmp(input logic s, input logic d, input logic m,
                        input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    signaling_i = s; dbl_i = d; inv_mask_i = m; opa_i = a; opb_i = b; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 flags", {zf_o, pf_o, cf_o, of_o, sf_o, af_o}, 0);
    chk("R12 we/sticky", {flag_we_o, inv_sticky_o}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_cmp(VECS[i].sig, VECS[i].dbl, VECS[i].mask, VECS[i].a, VECS[i].b);
      if (VECS[i].we) exp_zpc = VECS[i].zpc;
      exp_sticky = exp_sticky | VECS[i].inv;
      chk($sformatf("R1-4 zpc vec%0d", i), {zf_o, pf_o, cf_o}, exp_zpc);
      chk($sformatf("R5 aux vec%0d", i), {of_o, sf_o, af_o}, 0);
      chk($sformatf("R11 we vec%0d", i), flag_we_o, VECS[i].we);
      chk($sformatf("R9 sticky vec%0d", i), inv_sticky_o, exp_sticky);
    end

    // R11: idle cycle holds flags, no strobe
    @(negedge clk);
    chk("R11 idle we", flag_we_o, 0);
    chk("R11 idle flags", {zf_o, pf_o, cf_o}, exp_zpc);

    // R8: reset sticky, set equal flags, then unmasked fault
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 sticky after reset", inv_sticky_o, 0);
    rst_n = 1'b1;
    do_cmp(1'b0, 1'b0, 1'b1, 64'h3F800000, 64'h3F800000);
    chk("R4 equal before fault", {zf_o, pf_o, cf_o}, 3'b100);
    do_cmp(1'b1, 1'b0, 1'b0, 64'h7FC00000, 64'h3F800000);
    chk("R8 flags held", {zf_o, pf_o, cf_o}, 3'b100);
    chk("R8 no strobe", flag_we_o, 0);
    chk("R9 sticky on unmasked", inv_sticky_o, 1);
    chk("R6 signaling quiet NaN faults", {flag_we_o, inv_sticky_o}, 2'b01);
    // R9: a clean compare keeps the sticky bit
    do_cmp(1'b0, 1'b0, 1'b1, 64'h40000000, 64'h3F800000);
    chk("R9 sticky kept", inv_sticky_o, 1);
    chk("R2 after fault", {zf_o, pf_o, cf_o}, 3'b000);
    // R7: quiet variant, unmasked, quiet NaN -> no fault
    do_cmp(1'b0, 1'b1, 1'b0, 64'h3FF0000000000000, 64'h7FF8000000000001);
    chk("R7 quiet no fault we", flag_we_o, 1);
    chk("R1 unordered dbl", {zf_o, pf_o, cf_o, of_o, sf_o, af_o}, 6'b111000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule